// File: doc/BRIEF.md
# Gaussian Transmit Pulse Shaper

This block turns a serial transmit bit stream into a smoothed, signed frequency-deviation word for a downstream modulator or DAC. It runs on the filter clock and takes one new data bit every twelve filter clocks, so each bit covers twelve samples. Before filtering, each bit is mapped to +1 or -1 and pushed through a 12-tap constant-coefficient FIR with a bell-shaped (Gaussian, bandwidth-time 0.5) impulse response. The filter sum is then multiplied by a 3-bit programmable deviation factor and clipped to a 12-bit signed word.

Shaping runs only while both the filter enable and the transmit-mode flag are high. Otherwise the output is zero, the bit-phase counter returns to its start, and the tap history is cleared. This way every transmit burst starts from a known state with a fixed, known latency. With the default constants, full scale at the 100 % setting is 1637 LSB. That value stands for the nominal 350 kHz peak deviation.

Top module: `gauss_tx_shaper`

## Requirements
- R1: While `rst` is high at a clock edge, `dev_out` becomes 0 and the whole pipeline clears (accumulator 0, history all bit 0).
- R2: At any edge where `filt_en` and `tx_mode` are not both high, `dev_out` becomes 0.
- R3: Call the edges where both gates are high active edges. `tx_bit` is captured on the first active edge after activation and then on every 12th active edge. A change of `tx_bit` on any other active edge has no effect on the output.
- R4: The captured bit is mapped as 1 → +1 and 0 → -1. With the history full of ones the filter sum is +1310, and with the history full of zeros it is -1310. At code 4 the output is then +1637 or -1638.
- R5: The history holds 12 samples and takes one sample per active edge. The coefficients are 10, 28, 66, 130, 190, 231, 231, 190, 130, 66, 28, 10 (unsigned, symmetric, sum 1310).
- R6: `dev_out` = floor(S × (6 + `scale_code`) / 8), where S is the filter sum. Codes 0 to 7 therefore give 60 % to 130 % of the 100 % level in 10 % steps.
- R7: A scaled result above 2047 is output as 2047, and one below -2048 is output as -2048 (saturation, no wrap).
- R8: A bit captured at active edge E first reaches `dev_out` at edge E+3, given that all three edges are active.
- R9: At every inactive edge the history is reset to all bit 0. After re-activation, the filter builds up again from a -1 history.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Filter clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_bit | input | 1 | Serial transmit data |
| filt_en | input | 1 | Filter enable |
| tx_mode | input | 1 | Transmitter mode active |
| scale_code | input | 3 | Deviation scaling code, 0 = 60 % … 7 = 130 % |
| dev_out | output | 12 | Signed, registered frequency-deviation sample |

## Verification
The bound checker checks five things on every cycle: the output is zeroed when either gate is low, the captured bit holds between capture edges, the phase counter wraps at 12, the history clears when inactive, and the accumulator reaches its extreme sums for uniform histories. It also checks the output bound at the lowest gain. Three behaviours can only be shown by the bench's scenarios: the full convolution against arbitrary bit patterns, the exact three-edge latency, and saturation at the highest gain. The bench covers these by sweeping all eight scaling codes with pseudo-random bit streams, adding mid-bit glitches and gate toggles.

// File: rtl/gsh_pkg.sv
package gsh_pkg;

  // Half-profile of the symmetric Gaussian impulse response; index mirrored.
  function automatic int gsh_coef(input int k, input int taps);
    int h;
    h = (k < taps - 1 - k) ? k : taps - 1 - k;
    case (h)
      0:       return 10;
      1:       return 28;
      2:       return 66;
      3:       return 130;
      4:       return 190;
      5:       return 231;
      default: return 255;
    endcase
  endfunction

  function automatic int gsh_coef_sum(input int taps);
    int s;
    s = 0;
    for (int i = 0; i < taps; i++) s += gsh_coef(i, taps);
    return s;
  endfunction

endpackage

// File: rtl/gsh_symbol_sampler.sv
module gsh_symbol_sampler #(
  parameter int SPB  = 12,
  parameter int PH_W = $clog2(SPB)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            active,
  input  logic            tx_bit,
  output logic            sym,
  output logic [PH_W-1:0] phase
);

  localparam logic [PH_W-1:0] LAST = PH_W'(SPB - 1);

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      phase <= '0;
      sym   <= 1'b0;
    end else begin
      if (phase == '0) sym <= tx_bit;
      phase <= (phase == LAST) ? '0 : phase + 1'b1;
    end
  end

endmodule

// File: rtl/gsh_tap_line.sv
module gsh_tap_line
  import gsh_pkg::*;
#(
  parameter int TAPS  = 12,
  parameter int ACC_W = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    active,
  input  logic                    sym,
  output logic [TAPS-1:0]         taps,
  output logic signed [ACC_W-1:0] acc
);

  logic signed [ACC_W-1:0] term [TAPS];
  logic signed [ACC_W-1:0] sum;

  always_ff @(posedge clk) begin
    if (rst || !active) taps <= '0;
    else                taps <= {taps[TAPS-2:0], sym};
  end

  for (genvar k = 0; k < TAPS; k++) begin : g_term
    localparam logic signed [ACC_W-1:0] CK = ACC_W'(gsh_coef(k, TAPS));
    assign term[k] = taps[k] ? CK : -CK;
  end

  always_comb begin
    sum = '0;
    for (int i = 0; i < TAPS; i++) sum = sum + term[i];
  end

  always_ff @(posedge clk) begin
    if (rst) acc <= '0;
    else     acc <= sum;
  end

endmodule

// File: rtl/gsh_scaler.sv
module gsh_scaler #(
  parameter int ACC_W     = 12,
  parameter int OW        = 12,
  parameter int CODE_W    = 3,
  parameter int GAIN_BASE = 6,
  parameter int SHIFT     = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    active,
  input  logic [CODE_W-1:0]       code,
  input  logic signed [ACC_W-1:0] acc,
  output logic signed [OW-1:0]    dev
);

  localparam int GW = CODE_W + 2;
  localparam int PW = ACC_W + GW;
  localparam logic signed [PW-1:0] SAT_HI = PW'((1 << (OW - 1)) - 1);
  localparam logic signed [PW-1:0] SAT_LO = ~SAT_HI;

  logic signed [GW-1:0] gain;
  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] shifted;
  logic signed [OW-1:0] clipped;

  always_comb begin
    gain    = GW'(GAIN_BASE) + GW'(code);
    prod    = PW'(acc) * PW'(gain);
    shifted = prod >>> SHIFT;
    if (shifted > SAT_HI)      clipped = SAT_HI[OW-1:0];
    else if (shifted < SAT_LO) clipped = SAT_LO[OW-1:0];
    else                       clipped = shifted[OW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst || !active) dev <= '0;
    else                dev <= clipped;
  end

endmodule

// File: rtl/gauss_tx_shaper.sv
module gauss_tx_shaper
  import gsh_pkg::*;
#(
  parameter int TAPS      = 12,
  parameter int SPB       = 12,
  parameter int OW        = 12,
  parameter int CODE_W    = 3,
  parameter int GAIN_BASE = 6,
  parameter int SHIFT     = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tx_bit,
  input  logic                 filt_en,
  input  logic                 tx_mode,
  input  logic [CODE_W-1:0]    scale_code,
  output logic signed [OW-1:0] dev_out
);

  localparam int PH_W  = $clog2(SPB);
  localparam int ACC_W = $clog2(gsh_coef_sum(TAPS) + 1) + 1;

  logic                    active;
  logic                    sym_w;
  logic [PH_W-1:0]         phase_w;
  logic [TAPS-1:0]         taps_w;
  logic signed [ACC_W-1:0] acc_w;

  assign active = filt_en & tx_mode;

  gsh_symbol_sampler #(.SPB(SPB), .PH_W(PH_W)) u_sampler (
    .clk(clk), .rst(rst), .active(active), .tx_bit(tx_bit),
    .sym(sym_w), .phase(phase_w)
  );

  gsh_tap_line #(.TAPS(TAPS), .ACC_W(ACC_W)) u_taps (
    .clk(clk), .rst(rst), .active(active), .sym(sym_w),
    .taps(taps_w), .acc(acc_w)
  );

  gsh_scaler #(
    .ACC_W(ACC_W), .OW(OW), .CODE_W(CODE_W),
    .GAIN_BASE(GAIN_BASE), .SHIFT(SHIFT)
  ) u_scale (
    .clk(clk), .rst(rst), .active(active), .code(scale_code),
    .acc(acc_w), .dev(dev_out)
  );

endmodule

// File: rtl/gsh_checker.sv
module gsh_checker
  import gsh_pkg::*;
#(
  parameter int TAPS   = 12,
  parameter int SPB    = 12,
  parameter int OW     = 12,
  parameter int CODE_W = 3,
  parameter int PH_W   = 4,
  parameter int ACC_W  = 12
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    filt_en,
  input logic                    tx_mode,
  input logic [CODE_W-1:0]       scale_code,
  input logic signed [OW-1:0]    dev_out,
  input logic                    sym,
  input logic [PH_W-1:0]         phase,
  input logic [TAPS-1:0]         taps,
  input logic signed [ACC_W-1:0] acc
);

  localparam logic signed [ACC_W-1:0] SUM = ACC_W'(gsh_coef_sum(TAPS));
  localparam logic signed [OW-1:0]    LOW_BOUND = OW'(983);

  logic act;
  assign act = filt_en & tx_mode;

  p_idle_zero_r2: assert property (@(posedge clk) disable iff (rst)
    !act |=> dev_out == '0);

  p_sym_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (act && phase != '0) |=> $stable(sym));

  p_phase_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (act && phase == PH_W'(SPB - 1)) |=> phase == '0);

  p_ones_sum_r4: assert property (@(posedge clk) disable iff (rst)
    (&taps) |=> acc == SUM);

  p_zeros_sum_r4: assert property (@(posedge clk) disable iff (rst)
    (taps == '0) |=> acc == -SUM);

  p_low_gain_bound_r6: assert property (@(posedge clk) disable iff (rst)
    (act && scale_code == '0) |=> (dev_out <= LOW_BOUND && dev_out >= -LOW_BOUND));

  p_clear_r9: assert property (@(posedge clk) disable iff (rst)
    !act |=> taps == '0);

endmodule

bind gauss_tx_shaper gsh_checker #(
  .TAPS(TAPS), .SPB(SPB), .OW(OW), .CODE_W(CODE_W), .PH_W(PH_W), .ACC_W(ACC_W)
) u_chk (
  .clk(clk), .rst(rst), .filt_en(filt_en), .tx_mode(tx_mode),
  .scale_code(scale_code), .dev_out(dev_out), .sym(sym_w),
  .phase(phase_w), .taps(taps_w), .acc(acc_w)
);

// File: tb/gauss_tx_shaper_bench.sv
module gauss_tx_shaper_bench;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              tx_bit = 1'b0;
  logic              filt_en = 1'b0;
  logic              tx_mode = 1'b0;
  logic [2:0]        scale_code = 3'd4;
  logic signed [11:0] dev_out;

  always #5 clk = ~clk;

  gauss_tx_shaper u_gauss_tx_shaper (
    .clk(clk), .rst(rst), .tx_bit(tx_bit), .filt_en(filt_en),
    .tx_mode(tx_mode), .scale_code(scale_code), .dev_out(dev_out)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // Reference model state per the requirements (R3, R5, R6, R7, R9)
  int m_phase = 0;
  int m_sym = 0;
  int m_taps [12];
  int m_acc = 0;
  int m_out = 0;
  int coef [12] = '{10, 28, 66, 130, 190, 231, 231, 190, 130, 66, 28, 10};
  int lfsr = 16'hACE1;

  task automatic chk(input string tag, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: dev_out=%0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic int sat12(input int v);
    if (v > 2047)  return 2047;
    if (v < -2048) return -2048;
    return v;
  endfunction

  task automatic model_edge(input int b, input int act, input int code);
    int s;
    s = 0;
    for (int i = 0; i < 12; i++) s += (m_taps[i] != 0) ? coef[i] : -coef[i];
    m_out = act ? sat12((m_acc * (6 + code)) >>> 3) : 0;
    m_acc = s;
    if (act) begin
      for (int i = 11; i > 0; i--) m_taps[i] = m_taps[i-1];
      m_taps[0] = m_sym;
      if (m_phase == 0) m_sym = b;
      m_phase = (m_phase == 11) ? 0 : m_phase + 1;
    end else begin
      for (int i = 0; i < 12; i++) m_taps[i] = 0;
      m_sym = 0;
      m_phase = 0;
    end
  endtask

  task automatic step(input int b, input int en, input int md, input int code, input string tag);
    @(negedge clk);
    chk(tag, int'(dev_out), m_out);
    tx_bit = b[0];
    filt_en = en[0];
    tx_mode = md[0];
    scale_code = code[2:0];
    @(posedge clk);
    #1;
    model_edge(b, en & md, code);
  endtask

  task automatic peek(input string tag, input int exp);
    chk(tag, int'(dev_out), exp);
  endtask

  function automatic int next_bit();
    lfsr = ((lfsr >> 1) | (((lfsr ^ (lfsr >> 2) ^ (lfsr >> 3) ^ (lfsr >> 5)) & 1) << 15)) & 16'hFFFF;
    return lfsr & 1;
  endfunction

  // Send whole bits; with glitch set, tx_bit is inverted away from capture edges (R3)
  task automatic send_bits(input int n, input int fixed, input int val, input int code,
                           input int glitch, input string tag);
    for (int k = 0; k < n; k++) begin
      int b;
      b = fixed ? val : next_bit();
      for (int c = 0; c < 12; c++) begin
        int d;
        d = (glitch != 0 && m_phase != 0) ? 1 - b : b;
        step(d, 1, 1, code, tag);
      end
    end
  endtask

  initial begin
    for (int i = 0; i < 12; i++) m_taps[i] = 0;
    repeat (3) @(posedge clk);
    #1;
    peek("R1 reset value", 0);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    model_edge(0, 0, 4);

    // R5/R8: random convolution at 100 %
    send_bits(40, 0, 0, 4, 0, "R5 convolution code4");

    // R4: steady ones and zeros
    send_bits(3, 1, 1, 4, 0, "R4 steady ones");
    peek("R4 full ones level", 1637);
    send_bits(3, 1, 0, 4, 0, "R4 steady zeros");
    peek("R4 full zeros level", -1638);

    // R8: latency from capture edge
    step(1, 1, 1, 4, "R8 latency");
    peek("R8 edge E", -1638);
    step(1, 1, 1, 4, "R8 latency");
    peek("R8 edge E+1", -1638);
    step(1, 1, 1, 4, "R8 latency");
    peek("R8 edge E+2", -1638);
    step(1, 1, 1, 4, "R8 latency");
    peek("R8 edge E+3", -1613);
    for (int c = 4; c < 12; c++) step(1, 1, 1, 4, "R8 latency tail");

    // R6: sweep all scaling codes with random data
    for (int code = 0; code < 8; code++) begin
      send_bits(20, 0, 0, code, 0, "R6 scale sweep");
      send_bits(2, 1, 1, code, 0, "R6 scale ones");
      peek("R6 ones at code", sat12((1310 * (6 + code)) >>> 3));
    end

    // R7: saturation at highest gain
    send_bits(2, 1, 1, 7, 0, "R7 sat high");
    peek("R7 positive clip", 2047);
    send_bits(2, 1, 0, 7, 0, "R7 sat low");
    peek("R7 negative clip", -2048);

    // R3: mid-bit glitches ignored
    send_bits(30, 0, 0, 5, 1, "R3 glitch immunity");

    // R2: gate off via enable then via mode
    for (int c = 0; c < 7; c++) step(next_bit(), 0, 1, 4, "R2 enable low");
    peek("R2 enable low zero", 0);
    send_bits(10, 0, 0, 4, 0, "R9 restart after enable");
    for (int c = 0; c < 5; c++) step(next_bit(), 1, 0, 2, "R2 mode low");
    peek("R2 mode low zero", 0);

    // R9: restart builds from -1 history
    step(1, 1, 1, 4, "R9 restart");
    peek("R9 first active edge", -1638);
    send_bits(10, 0, 0, 3, 0, "R9 restart after mode");

    step(0, 0, 0, 4, "R2 final idle");
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule